// File: doc/BRIEF.md
# Microcoded Bus Cycle Controller

This block links a microprogrammed processor core to an asynchronous shared system bus. Each microinstruction may carry an 8-bit bus-control field. When that field asks for the bus, the block takes a copy of the address, write data and transfer type. It then runs the whole transaction by itself: it requests ownership, places the address and data on the bus one cycle before the master strobe, and waits for the slave's acknowledge. It drops the strobe and waits for the acknowledge to fall before it calls the cycle complete. The microinstruction never drives the handshake lines directly.

The field can also freeze the core. When its pause bit is set, the core clock-enable output stays low until the transaction has fully finished. The field can ask for a word-alignment check, and a failed check ends the cycle with an error pulse and no bus activity. A programmable watchdog ends a strobe that no slave answers. Requests from other bus masters, such as DMA devices, are granted only between processor cycles. A processor cycle that arrives while such a master owns the bus waits until that master lets go. Two further fields, the register-select pair and the extended-mode flag, pass straight through to the core.

FSM states and transitions:
- IDLE moves to DMA on a DMA request. Otherwise an accepted request moves it to REQ, or to FAULT if the alignment check fails.
- DMA stays while the DMA request is held. When the request drops, DMA moves to REQ or FAULT if a processor request is pending, and to IDLE if not.
- REQ moves to SETUP on grant.
- SETUP moves to STROBE after one cycle.
- STROBE moves to RELEASE on acknowledge, and to TIMEOUT when the watchdog expires.
- RELEASE moves to IDLE once the acknowledge falls.
- FAULT and TIMEOUT each return to IDLE after one cycle.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset the block holds bus_req, bus_msync, dma_grant, bus_err and bus_timeout at 0, drives 0 on bus_addr, bus_wdata and bus_ttype, and holds core_clk_en at 1.
- R2: Field bits 7:6 appear on reg_sel at all times. ext_mode equals ctl_valid AND bit 5. Neither of these fields starts a bus cycle when bit 4 is 0.
- R3: A request is accepted when ctl_valid, core_clk_en and field bit 4 are all 1. The block then raises bus_req. bus_msync rises only after bus_grant has been seen, and only when the latched address and data have been on bus_addr and bus_wdata for at least one cycle before it.
- R4: While bus_msync is high, bus_addr, bus_wdata and bus_ttype carry the latched address, the latched data and field bits 1:0. bus_msync stays high until bus_ssync is seen, then falls, and the cycle ends only after bus_ssync falls.
- R5: With field bit 3 set, core_clk_en is 0 from the cycle after acceptance until the cycle after the cycle completes. A normal handshake with an acknowledge after k strobe cycles stalls the core for k+3 cycles. With bit 3 clear, core_clk_en stays 1.
- R6: If field bit 2 is set and address bit 0 is 1, bus_err pulses for one cycle, bus_req and bus_msync stay 0, and the stall is released. If bit 2 is clear, an odd address transfers normally.
- R7: If bus_ssync does not arrive within tmo_limit strobe cycles, bus_msync falls after exactly tmo_limit cycles, bus_timeout pulses for one cycle, and the stall is released.
- R8: A dma_req seen while the block is idle raises dma_grant on the next cycle and holds it for as long as dma_req stays high. A DMA request wins over a processor request that arrives in the same cycle. A processor request accepted during DMA ownership does not raise bus_req until dma_req falls, and then runs normally.
- R9: A dma_req that arrives during a processor cycle is not granted while bus_req is high. It is granted once that cycle ends.
- R10: A new bus request that arrives while a cycle is in flight is ignored: no second strobe is issued and its address never appears on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_valid | input | 1 | Current microinstruction carries a bus-control field |
| ctl_field | input | 8 | Bus-control field |
| addr_in | input | AW | Address register contents |
| wdata_in | input | DW | Data register contents |
| tmo_limit | input | TW | Acknowledge timeout in strobe cycles |
| core_clk_en | output | 1 | Clock enable to the core |
| reg_sel | output | 2 | Register address multiplexer select |
| ext_mode | output | 1 | Extended microinstruction mode flag |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus data |
| bus_ttype | output | 2 | Bus transfer-type lines |
| bus_msync | output | 1 | Master sync strobe |
| bus_ssync | input | 1 | Slave sync acknowledge |
| bus_err | output | 1 | Misaligned word access pulse |
| bus_timeout | output | 1 | Acknowledge timeout pulse |
| dma_req | input | 1 | Non-processor master request |
| dma_grant | output | 1 | Grant to non-processor master |

## Verification
The handshake is run with acknowledge latencies of one and four strobe cycles, both with and without pause. The latency test shows that the stall length follows the slave rather than a fixed count, and the pause test shows that stalling is controlled only by bit 3. Odd addresses are sent with and without the alignment check, which separates the error path from ordinary byte traffic. A slave that never answers shows the timeout path. DMA requests are placed before, together with and during a processor cycle, and a second request is sent while a cycle is in flight. Together these show that ownership is serialised and that new commands are ignored while a cycle is active.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_DMA, S_REQ, S_SETUP, S_STROBE, S_RELEASE, S_FAULT, S_TIMEOUT
    } bcc_state_e;

    // Packed in field order: [7:6] reg select, [5] ext mode, [4] own,
    // [3] pause, [2] alignment check, [1:0] transfer type.
    typedef struct packed {
        logic [1:0] reg_sel;
        logic       ext_mode;
        logic       own;
        logic       pause;
        logic       align_chk;
        logic [1:0] ttype;
    } bus_ctl_t;
endpackage

// File: rtl/bcc_field_decode.sv
module bcc_field_decode
    import bcc_pkg::*;
(
    input  logic       valid,
    input  logic [7:0] field,
    output bus_ctl_t   ctl,
    output logic       ext_mode,
    output logic [1:0] reg_sel
);
    always_comb begin
        ctl      = bus_ctl_t'(field);
        ext_mode = valid & ctl.ext_mode;
        reg_sel  = ctl.reg_sel;
    end
endmodule

// File: rtl/bcc_watchdog.sv
module bcc_watchdog #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;
    logic [TW:0]   cnt_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    always_comb begin
        cnt_next = {1'b0, cnt} + (TW+1)'(1);
        expired  = run && (cnt_next >= {1'b0, limit});
    end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_valid,
    input  logic [7:0]    ctl_field,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic [TW-1:0] tmo_limit,
    output logic          core_clk_en,
    output logic [1:0]    reg_sel,
    output logic          ext_mode,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic [1:0]    bus_ttype,
    output logic          bus_msync,
    input  logic          bus_ssync,
    output logic          bus_err,
    output logic          bus_timeout,
    input  logic          dma_req,
    output logic          dma_grant
);
    bcc_state_e    state, nxt;
    bus_ctl_t      ctl;
    logic          act, cmd_pause, cmd_bad;
    logic [1:0]    cmd_tt;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          start, bad_now, go, bad_sel, expired, drive;

    bcc_field_decode u_dec (
        .valid    (ctl_valid),
        .field    (ctl_field),
        .ctl      (ctl),
        .ext_mode (ext_mode),
        .reg_sel  (reg_sel)
    );

    bcc_watchdog #(.TW(TW)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_STROBE),
        .limit   (tmo_limit),
        .expired (expired)
    );

    assign start   = ctl_valid && ctl.own && core_clk_en && !act;
    assign bad_now = ctl.align_chk && addr_in[0];
    assign go      = act || start;
    assign bad_sel = act ? cmd_bad : bad_now;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (dma_req) nxt = S_DMA;
                       else if (start) nxt = bad_now ? S_FAULT : S_REQ;
            S_DMA:     if (!dma_req) nxt = go ? (bad_sel ? S_FAULT : S_REQ) : S_IDLE;
            S_REQ:     if (bus_grant) nxt = S_SETUP;
            S_SETUP:   nxt = S_STROBE;
            S_STROBE:  if (bus_ssync) nxt = S_RELEASE;
                       else if (expired) nxt = S_TIMEOUT;
            S_RELEASE: if (!bus_ssync) nxt = S_IDLE;
            S_FAULT:   nxt = S_IDLE;
            S_TIMEOUT: nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // state register and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            act       <= 1'b0;
            cmd_pause <= 1'b0;
            cmd_bad   <= 1'b0;
            cmd_tt    <= '0;
            addr_q    <= '0;
            data_q    <= '0;
        end else begin
            state <= nxt;
            if (state == S_FAULT || state == S_TIMEOUT ||
                (state == S_RELEASE && !bus_ssync)) begin
                act <= 1'b0;
            end else if (start) begin
                act       <= 1'b1;
                cmd_pause <= ctl.pause;
                cmd_bad   <= bad_now;
                cmd_tt    <= ctl.ttype;
                addr_q    <= addr_in;
                data_q    <= wdata_in;
            end
        end
    end

    // outputs
    always_comb begin
        drive       = (state == S_SETUP) || (state == S_STROBE) || (state == S_RELEASE);
        bus_req     = drive || (state == S_REQ);
        bus_msync   = (state == S_STROBE);
        bus_addr    = drive ? addr_q : '0;
        bus_wdata   = drive ? data_q : '0;
        bus_ttype   = drive ? cmd_tt : '0;
        bus_err     = (state == S_FAULT);
        bus_timeout = (state == S_TIMEOUT);
        dma_grant   = (state == S_DMA);
        core_clk_en = !(act && cmd_pause);
    end
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_clk_en,
    input logic          bus_req,
    input logic [AW-1:0] bus_addr,
    input logic          bus_msync,
    input logic          bus_ssync,
    input logic          bus_err,
    input logic          bus_timeout,
    input logic          dma_grant
);
    assert_strobe_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_msync |-> bus_req);

    assert_addr_settled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_msync) |-> ($past(bus_addr) == bus_addr) && $past(bus_req));

    assert_strobe_ends_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_msync) && !bus_timeout) |-> $past(bus_ssync));

    assert_release_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> (!bus_ssync && !bus_msync));

    assert_fault_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (!bus_msync && !bus_req));

    assert_dma_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_grant |-> (!bus_msync && !bus_req));
endmodule

bind bus_cycle_ctrl bcc_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_clk_en (core_clk_en),
    .bus_req     (bus_req),
    .bus_addr    (bus_addr),
    .bus_msync   (bus_msync),
    .bus_ssync   (bus_ssync),
    .bus_err     (bus_err),
    .bus_timeout (bus_timeout),
    .dma_grant   (dma_grant)
);

// File: tb/tb_bus_cycle_ctrl.sv
module tb_bus_cycle_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_valid = 1'b0;
    logic [7:0]    ctl_field = '0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] wdata_in = '0;
    logic [TW-1:0] tmo_limit = 8'd8;
    logic          core_clk_en;
    logic [1:0]    reg_sel;
    logic          ext_mode;
    logic          bus_req;
    logic          bus_grant = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [1:0]    bus_ttype;
    logic          bus_msync;
    logic          bus_ssync = 1'b0;
    logic          bus_err;
    logic          bus_timeout;
    logic          dma_req = 1'b0;
    logic          dma_grant;

    int checks = 0;
    int fails  = 0;

    // results of one served window
    int stall_n, msync_n, err_n, tmo_n, req_n, bad_addr_n, setup_bad_n, dma_conflict_n, dma_seen_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_ctrl #(.AW(AW), .DW(DW), .TW(TW)) dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // field: {reg_sel[1:0], ext, own, pause, chk, tt[1:0]}
    task automatic issue(input logic [7:0] f, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ctl_valid = 1'b1;
        ctl_field = f;
        addr_in   = a;
        wdata_in  = d;
    endtask

    // Acts as the slave for a fixed window; ack_lat 0 means never acknowledge.
    task automatic serve(input int ack_lat, input logic [AW-1:0] ea, input logic [DW-1:0] ed,
                         input logic [1:0] et, input bit alt, input logic [AW-1:0] alt_a,
                         input int dma_at);
        bit prev_msync = 1'b0;
        logic [AW-1:0] prev_addr = '0;
        stall_n = 0; msync_n = 0; err_n = 0; tmo_n = 0; req_n = 0;
        bad_addr_n = 0; setup_bad_n = 0; dma_conflict_n = 0; dma_seen_n = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!core_clk_en) stall_n++;
            if (bus_err) err_n++;
            if (bus_timeout) tmo_n++;
            if (bus_req) req_n++;
            if (dma_grant) dma_seen_n++;
            if (dma_grant && bus_req) dma_conflict_n++;
            if (bus_msync) begin
                msync_n++;
                if (bus_addr != ea || bus_wdata != ed || bus_ttype != et) bad_addr_n++;
                if (!prev_msync && prev_addr != ea) setup_bad_n++;
            end
            prev_msync = bus_msync;
            prev_addr  = bus_addr;
            // drive
            if (i == 0 && alt) begin
                ctl_valid = 1'b1;
                ctl_field = 8'b0001_0001;
                addr_in   = alt_a;
            end else begin
                ctl_valid = 1'b0;
            end
            bus_grant = bus_req;
            if (bus_msync && ack_lat > 0 && msync_n >= ack_lat) bus_ssync = 1'b1;
            else if (!bus_msync) bus_ssync = 1'b0;
            if (dma_at >= 0 && i == dma_at) dma_req = 1'b1;
        end
        dma_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(core_clk_en == 1'b1, "R1", "core_clk_en after reset", core_clk_en, 1);
        chk({bus_req, bus_msync, dma_grant, bus_err, bus_timeout} == 5'b0, "R1",
            "control outputs after reset", {bus_req, bus_msync, dma_grant, bus_err, bus_timeout}, 0);
        chk(bus_addr == 0 && bus_wdata == 0 && bus_ttype == 0, "R1", "bus value after reset",
            bus_addr, 0);
    endtask

    task automatic t_fields;
        @(negedge clk);
        ctl_valid = 1'b1;
        ctl_field = 8'b1010_0000;
        #1;
        chk(ext_mode == 1'b1, "R2", "ext_mode with bit5", ext_mode, 1);
        chk(reg_sel == 2'b10, "R2", "reg_sel bits 7:6", reg_sel, 2);
        @(negedge clk);
        ctl_valid = 1'b0;
        #1;
        chk(ext_mode == 1'b0, "R2", "ext_mode without valid", ext_mode, 0);
        @(negedge clk);
        chk(bus_req == 1'b0, "R2", "no bus cycle without bit4", bus_req, 0);
    endtask

    task automatic t_paused_word(input int lat, input logic [1:0] tt);
        issue({4'b0001, 1'b1, 1'b1, tt}, 16'h1234, 16'hBEEF);
        serve(lat, 16'h1234, 16'hBEEF, tt, 1'b0, '0, -1);
        chk(msync_n == lat, "R4", "strobe length", msync_n, lat);
        chk(bad_addr_n == 0, "R4", "bus value mismatches during strobe", bad_addr_n, 0);
        chk(setup_bad_n == 0, "R3", "address not settled before strobe", setup_bad_n, 0);
        chk(stall_n == lat + 3, "R5", "paused stall length", stall_n, lat + 3);
        chk(core_clk_en == 1'b1 && bus_req == 1'b0, "R4", "idle after cycle", bus_req, 0);
    endtask

    task automatic t_unpaused;
        issue(8'b0001_0010, 16'h0400, 16'h0055);
        serve(2, 16'h0400, 16'h0055, 2'b10, 1'b0, '0, -1);
        chk(stall_n == 0, "R5", "stall with pause clear", stall_n, 0);
        chk(msync_n == 2, "R4", "unpaused strobe length", msync_n, 2);
    endtask

    task automatic t_misaligned;
        issue(8'b0001_1101, 16'h0101, 16'h0000);
        serve(1, 16'h0101, 16'h0000, 2'b01, 1'b0, '0, -1);
        chk(err_n == 1, "R6", "bus_err pulses", err_n, 1);
        chk(req_n == 0 && msync_n == 0, "R6", "bus touched on fault", req_n + msync_n, 0);
        chk(stall_n == 1, "R6", "fault stall length", stall_n, 1);
        // same odd address without the check transfers normally
        issue(8'b0001_1001, 16'h0101, 16'h0077);
        serve(1, 16'h0101, 16'h0077, 2'b01, 1'b0, '0, -1);
        chk(err_n == 0 && msync_n == 1, "R6", "unchecked odd address strobes", msync_n, 1);
    endtask

    task automatic t_timeout;
        tmo_limit = 8'd5;
        issue(8'b0001_1000, 16'h0200, 16'h0001);
        serve(0, 16'h0200, 16'h0001, 2'b00, 1'b0, '0, -1);
        chk(msync_n == 5, "R7", "strobe cycles before timeout", msync_n, 5);
        chk(tmo_n == 1, "R7", "bus_timeout pulses", tmo_n, 1);
        chk(stall_n == 8, "R7", "timeout stall length", stall_n, 8);
        tmo_limit = 8'd8;
    endtask

    task automatic t_dma_first;
        @(negedge clk);
        dma_req = 1'b1;
        ctl_valid = 1'b1;
        ctl_field = 8'b0001_1000;
        addr_in   = 16'h0600;
        wdata_in  = 16'h0C0C;
        @(negedge clk);
        ctl_valid = 1'b0;
        chk(dma_grant == 1'b1, "R8", "dma wins same-cycle request", dma_grant, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(bus_req == 1'b0 && dma_grant == 1'b1, "R8", "processor waits during dma",
                bus_req, 0);
            chk(core_clk_en == 1'b0, "R8", "pending paused request stalls", core_clk_en, 0);
        end
        dma_req = 1'b0;
        serve(1, 16'h0600, 16'h0C0C, 2'b00, 1'b0, '0, -1);
        chk(msync_n == 1 && bad_addr_n == 0, "R8", "deferred cycle runs", msync_n, 1);
        chk(stall_n == 4, "R8", "deferred cycle stall", stall_n, 4);
    endtask

    task automatic t_dma_during;
        issue(8'b0001_1011, 16'h0800, 16'h4242);
        serve(4, 16'h0800, 16'h4242, 2'b11, 1'b0, '0, 1);
        chk(dma_conflict_n == 0, "R9", "dma granted while bus owned", dma_conflict_n, 0);
        chk(dma_seen_n > 0, "R9", "dma granted after cycle", dma_seen_n, 1);
        chk(msync_n == 4, "R9", "processor cycle completes", msync_n, 4);
    endtask

    task automatic t_ignored;
        issue(8'b0001_0001, 16'h0A00, 16'h1111);
        serve(3, 16'h0A00, 16'h1111, 2'b01, 1'b1, 16'h0B00, -1);
        chk(msync_n == 3, "R10", "only one strobe", msync_n, 3);
        chk(bad_addr_n == 0, "R10", "second address on bus", bad_addr_n, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_fields();
        t_paused_word(1, 2'b01);
        t_paused_word(4, 2'b10);
        t_unpaused();
        t_misaligned();
        t_timeout();
        t_dma_first();
        t_dma_during();
        t_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule